// File: doc/BRIEF.md
# Challenge-Token Window Watchdog

This block supervises a host processor by asking it to prove that it is alive. The block holds a 16-bit token that the host reads and writes back as its answer. A refresh is good only when the answer equals the token. After each good refresh the token changes to the other of two fixed keys, so a stuck host that keeps writing the same value cannot keep the watchdog satisfied.

After reset the block is in an initial phase. The first good refresh ends that phase. From then on, every period is split into a closed half and an open half of equal length, counted in ticks. In window mode a refresh in the closed half is rejected. In timeout mode the window is always open. Each rejected refresh, and each period that ends with no refresh, counts as an error. When the error count reaches its configured limit, a sticky fault output is raised. A run of good refreshes lowers the count by one.

Top module: `token_window_wdog`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `token` is 0x5AB2, `err_cnt` is 0, and `init_done`, `fault`, `ok_pulse` and `nok_pulse` are all 0.
- R2: A write whose data equals `token` and that is not in the closed half is good. One cycle later `ok_pulse` is 1 and `token` has switched to the other key (0x5AB2 and 0xD564 swap). After any rejected write, `token` stays unchanged.
- R3: During the initial phase a good write is accepted at any time. In the cycle after it, `init_done` rises to 1 and stays 1 until reset. A new period then starts, beginning with its closed half.
- R4: With `cfg_timeout_mode` = 0 and `init_done` = 1, a write made while fewer than HALF_TICKS ticks have passed since the period started gives `nok_pulse` one cycle later. This holds even when the key is correct.
- R5: In the open half, or at any time with `cfg_timeout_mode` = 1, a write with the wrong key gives `nok_pulse` one cycle later. Such a write does not restart the period.
- R6: Once `init_done` is 1, the tick that completes 2*HALF_TICKS ticks since the period started, with no good write, gives `nok_pulse` one cycle later. That tick also starts a new period. This applies in both modes.
- R7: Each NOK raises `err_cnt` by one, but never above `cfg_err_limit`. When `err_cnt` reaches `cfg_err_limit`, `fault` goes to 1 and stays 1 until reset.
- R8: After `cfg_ok_run` consecutive OK results, `err_cnt` goes down by one if it is above 0. A value of 0 in `cfg_ok_run` acts as 1. Any NOK clears the run of OK results.
- R9: If INIT_TICKS ticks pass in the initial phase with no good write, `fault` goes to 1 one cycle after the last of those ticks. A later good write still ends the initial phase.
- R10: When a write and a tick arrive in the same cycle, the tick is ignored: neither the period counter nor the initial-phase counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base strobe, one count per cycle high |
| ans_we | input | 1 | Answer write strobe |
| ans_data | input | 16 | Answer value |
| cfg_timeout_mode | input | 1 | 1 = always-open timeout mode, 0 = closed/open window mode |
| cfg_err_limit | input | CNT_W | Error count at which the fault is raised |
| cfg_ok_run | input | RUN_W | Number of consecutive OK results needed for one decrement |
| token | output | 16 | Current expected answer |
| ok_pulse | output | 1 | One-cycle pulse for an accepted refresh |
| nok_pulse | output | 1 | One-cycle pulse for a rejected or missing refresh |
| err_cnt | output | CNT_W | Error counter |
| init_done | output | 1 | Initial phase closed |
| fault | output | 1 | Sticky fault (error limit reached or initial phase expired) |

## Verification
The assertions assume that the configuration inputs stay steady between resets, and that `cfg_err_limit` is at least 1. The saturation and increment checks compare `err_cnt` against the live limit. The stimulus therefore sets the limit and the run length before reset is released and never changes them. It switches only the mode bit, and only at a point between refreshes. Writes are placed at tick counts chosen to hit the last closed tick, the first open tick and the period end. Same-cycle write-and-tick cases are driven deliberately so that their outcome shows whether the tick was counted.

// File: rtl/tokwd_pkg.sv
// Shared constants and types for the challenge-token window watchdog.
package tokwd_pkg;
    localparam logic [15:0] KEY_A = 16'h5AB2;  // value after reset
    localparam logic [15:0] KEY_B = 16'hD564;

    // Result of the current cycle's refresh evaluation
    typedef struct packed {
        logic ok;
        logic nok;
    } verdict_t;
endpackage

// File: rtl/tokwd_token.sv
// Token register: holds the expected answer and swaps between the two keys
// on each accepted refresh. Assumes adv is a single-cycle qualified strobe.
module tokwd_token
    import tokwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    output logic [15:0] token
);
    // Swap to the other key on an accepted refresh
    always_ff @(posedge clk) begin
        if (!rst_n)
            token <= KEY_A;
        else if (adv)
            token <= (token == KEY_A) ? KEY_B : KEY_A;
    end
endmodule

// File: rtl/tokwd_timer.sv
// Phase and window timing: counts ticks through the initial phase and the
// closed/open period, and classifies each answer write or period end.
// Assumes HALF_TICKS >= 1 and INIT_TICKS >= 1; a write in the same cycle
// as a tick suppresses that tick.
module tokwd_timer
    import tokwd_pkg::*;
#(
    parameter int HALF_TICKS = 8,
    parameter int INIT_TICKS = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     ans_we,
    input  logic     ans_match,
    input  logic     timeout_mode,
    output verdict_t ev,
    output logic     init_done,
    output logic     init_expired
);
    localparam int PERIOD = 2 * HALF_TICKS;
    localparam int PER_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int INIT_W = $clog2(INIT_TICKS + 1);
    localparam logic [PER_W-1:0]  HALF_L = PER_W'(HALF_TICKS);
    localparam logic [PER_W-1:0]  LAST_P = PER_W'(PERIOD - 1);
    localparam logic [INIT_W-1:0] LAST_I = INIT_W'(INIT_TICKS - 1);

    logic [PER_W-1:0]  pcnt;
    logic [INIT_W-1:0] icnt;
    logic              closed;
    logic              tick_eff;

    // Classify the current cycle: accepted, rejected, or period expiry
    always_comb begin
        closed   = !timeout_mode && init_done && (pcnt < HALF_L);
        tick_eff = tick && !ans_we;
        ev.ok    = ans_we && ans_match && !closed;
        ev.nok   = (ans_we && !(ans_match && !closed)) ||
                   (tick_eff && init_done && (pcnt == LAST_P));
    end

    // Advance the initial-phase and period counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt         <= '0;
            icnt         <= '0;
            init_done    <= 1'b0;
            init_expired <= 1'b0;
        end else if (!init_done) begin
            if (ev.ok) begin
                init_done <= 1'b1;
                pcnt      <= '0;
            end else if (tick_eff && !init_expired) begin
                if (icnt == LAST_I)
                    init_expired <= 1'b1;
                else
                    icnt <= icnt + 1'b1;
            end
        end else begin
            if (ev.ok)
                pcnt <= '0;
            else if (tick_eff)
                pcnt <= (pcnt == LAST_P) ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tokwd_errcnt.sv
// Error counter: adds one per NOK up to the limit and raises a sticky fault
// there; a run of consecutive OKs takes one off. Assumes ok and nok are
// never high together.
module tokwd_errcnt #(
    parameter int CNT_W = 4,
    parameter int RUN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ok,
    input  logic             nok,
    input  logic [CNT_W-1:0] limit,
    input  logic [RUN_W-1:0] ok_run,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_fault
);
    logic [RUN_W-1:0] run;
    logic [RUN_W:0]   run_nxt;
    logic [RUN_W:0]   run_goal;
    logic [CNT_W:0]   err_inc;

    // Next-value arithmetic for the counters
    always_comb begin
        run_nxt  = {1'b0, run} + 1'b1;
        run_goal = (ok_run == '0) ? (RUN_W+1)'(1) : {1'b0, ok_run};
        err_inc  = {1'b0, err_cnt} + 1'b1;
    end

    // Update error count, OK run and sticky fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt   <= '0;
            run       <= '0;
            err_fault <= 1'b0;
        end else if (nok) begin
            run <= '0;
            if (err_cnt < limit)
                err_cnt <= err_inc[CNT_W-1:0];
            if (err_inc >= {1'b0, limit})
                err_fault <= 1'b1;
        end else if (ok) begin
            if (run_nxt >= run_goal) begin
                run <= '0;
                if (err_cnt != '0)
                    err_cnt <= err_cnt - 1'b1;
            end else begin
                run <= run_nxt[RUN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/token_window_wdog.sv
// Challenge-token window watchdog top. The host answers with the current
// token; answers are judged against the initial phase, the closed/open
// window or the timeout mode, and errors feed a saturating counter.
// Assumes configuration inputs are steady between resets.
module token_window_wdog
    import tokwd_pkg::*;
#(
    parameter int HALF_TICKS = 8,
    parameter int INIT_TICKS = 256,
    parameter int CNT_W      = 4,
    parameter int RUN_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ans_we,
    input  logic [15:0]      ans_data,
    input  logic             cfg_timeout_mode,
    input  logic [CNT_W-1:0] cfg_err_limit,
    input  logic [RUN_W-1:0] cfg_ok_run,
    output logic [15:0]      token,
    output logic             ok_pulse,
    output logic             nok_pulse,
    output logic [CNT_W-1:0] err_cnt,
    output logic             init_done,
    output logic             fault
);
    verdict_t ev;
    logic     init_expired;
    logic     err_fault;
    logic     ans_match;

    assign ans_match = (ans_data == token);

    tokwd_token u_token (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ev.ok),
        .token (token)
    );

    tokwd_timer #(
        .HALF_TICKS (HALF_TICKS),
        .INIT_TICKS (INIT_TICKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .ans_we       (ans_we),
        .ans_match    (ans_match),
        .timeout_mode (cfg_timeout_mode),
        .ev           (ev),
        .init_done    (init_done),
        .init_expired (init_expired)
    );

    tokwd_errcnt #(
        .CNT_W (CNT_W),
        .RUN_W (RUN_W)
    ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .ok        (ev.ok),
        .nok       (ev.nok),
        .limit     (cfg_err_limit),
        .ok_run    (cfg_ok_run),
        .err_cnt   (err_cnt),
        .err_fault (err_fault)
    );

    // Register the verdict as one-cycle result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_pulse  <= 1'b0;
            nok_pulse <= 1'b0;
        end else begin
            ok_pulse  <= ev.ok;
            nok_pulse <= ev.nok;
        end
    end

    assign fault = err_fault | init_expired;
endmodule

// File: rtl/tokwd_chk.sv
// Checker for token_window_wdog, attached by bind. Assumes cfg_err_limit
// >= 1 and configuration steady while out of reset.
module tokwd_chk
    import tokwd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      token,
    input logic             ok_pulse,
    input logic             nok_pulse,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] cfg_err_limit,
    input logic             init_done,
    input logic             fault
);
    p_key_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (token == KEY_A) || (token == KEY_B));

    p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_pulse && nok_pulse));

    p_token_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ok_pulse |-> (token != $past(token)));

    p_token_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_pulse |-> $stable(token));

    p_init_by_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ok_pulse);

    p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done) |-> init_done);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= cfg_err_limit);

    p_nok_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nok_pulse && ($past(err_cnt) < cfg_err_limit)) |->
        ({1'b0, err_cnt} == {1'b0, $past(err_cnt)} + 1'b1));

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault) |-> fault);

    p_limit_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == cfg_err_limit) |-> fault);
endmodule

bind token_window_wdog tokwd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .token         (token),
    .ok_pulse      (ok_pulse),
    .nok_pulse     (nok_pulse),
    .err_cnt       (err_cnt),
    .cfg_err_limit (cfg_err_limit),
    .init_done     (init_done),
    .fault         (fault)
);

// File: tb/sim_token_window_wdog.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares after each edge.
module sim_token_window_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 8;
    localparam int INIT  = 256;
    localparam int CW    = 4;
    localparam int RW    = 3;
    localparam logic [15:0] KA = 16'h5AB2;
    localparam logic [15:0] KB = 16'hD564;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          ans_we = 1'b0;
    logic [15:0]   ans_data = '0;
    logic          cfg_timeout_mode = 1'b0;
    logic [CW-1:0] cfg_err_limit = 4'd4;
    logic [RW-1:0] cfg_ok_run = 3'd2;
    logic [15:0]   token;
    logic          ok_pulse, nok_pulse, init_done, fault;
    logic [CW-1:0] err_cnt;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        string       tag;
        logic [15:0] tok;
        logic        ok;
        logic        nok;
        logic [3:0]  err;
        logic        idone;
        logic        flt;
    } exp_t;
    exp_t q[$];

    // Reference state derived from the requirements
    logic [15:0] m_tok;
    bit m_init, m_iexp, m_fault;
    int m_icnt, m_pcnt, m_err, m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    token_window_wdog #(.HALF_TICKS(HALF), .INIT_TICKS(INIT),
                        .CNT_W(CW), .RUN_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ans_we(ans_we),
        .ans_data(ans_data), .cfg_timeout_mode(cfg_timeout_mode),
        .cfg_err_limit(cfg_err_limit), .cfg_ok_run(cfg_ok_run),
        .token(token), .ok_pulse(ok_pulse), .nok_pulse(nok_pulse),
        .err_cnt(err_cnt), .init_done(init_done), .fault(fault));

    task automatic chk(string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    task automatic model_reset();
        m_tok = KA; m_init = 0; m_iexp = 0; m_fault = 0;
        m_icnt = 0; m_pcnt = 0; m_err = 0; m_run = 0;
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(string tag, bit tk, bit we, logic [15:0] d);
        exp_t e;
        bit closed, good, bad, tmo;
        int goal;
        @(negedge clk);
        tick = tk; ans_we = we; ans_data = d;
        closed = !cfg_timeout_mode && m_init && (m_pcnt < HALF);
        good = we && (d == m_tok) && !closed;
        bad  = we && !good;
        tmo  = !we && tk && m_init && (m_pcnt == 2*HALF-1);
        goal = (cfg_ok_run == 0) ? 1 : int'(cfg_ok_run);
        if (good) begin
            m_tok  = (m_tok == KA) ? KB : KA;
            m_init = 1;
            m_pcnt = 0;
            m_run++;
            if (m_run >= goal) begin
                m_run = 0;
                if (m_err > 0) m_err--;
            end
        end else if (!we && tk) begin
            if (m_init) m_pcnt = tmo ? 0 : m_pcnt + 1;
            else if (!m_iexp) begin
                if (m_icnt == INIT-1) begin m_iexp = 1; m_fault = 1; end
                else m_icnt++;
            end
        end
        if (bad || tmo) begin
            m_run = 0;
            if (m_err < int'(cfg_err_limit)) m_err++;
            if (m_err >= int'(cfg_err_limit)) m_fault = 1;
        end
        e.tag = tag; e.tok = m_tok; e.ok = good; e.nok = bad || tmo;
        e.err = 4'(m_err); e.idone = m_init; e.flt = m_fault;
        q.push_back(e);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 16'h0);
    endtask

    // Monitor: compare queued expectations away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " token"},     token,     e.tok);
                chk({e.tag, " ok_pulse"},  ok_pulse,  e.ok);
                chk({e.tag, " nok_pulse"}, nok_pulse, e.nok);
                chk({e.tag, " err_cnt"},   err_cnt,   e.err);
                chk({e.tag, " init_done"}, init_done, e.idone);
                chk({e.tag, " fault"},     fault,     e.flt);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 0; ans_we = 0;
        repeat (3) @(negedge clk);
        model_reset();
        chk("R1 token in reset", token, KA);
        chk("R1 err_cnt in reset", err_cnt, 0);
        chk("R1 init_done in reset", init_done, 0);
        chk("R1 fault in reset", fault, 0);
        chk("R1 pulses in reset", {ok_pulse, nok_pulse}, 0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        step("R1 idle after reset", 1'b0, 1'b0, 16'h0);
        step("R5 bad key in initial phase", 1'b0, 1'b1, 16'h1234);
        idle("R3 initial ticks", 5);
        step("R3 good key closes initial phase", 1'b0, 1'b1, KA);
        idle("R4 closed ticks", 3);
        step("R4 right key in closed half", 1'b0, 1'b1, KB);
        idle("R4 reach open half", 5);
        step("R2 good key in open half", 1'b0, 1'b1, KB);
        idle("R4 reach first open tick", 8);
        step("R8 second OK decrements", 1'b0, 1'b1, KA);
        idle("R10 reach last closed tick", 7);
        step("R10 write with tick", 1'b1, 1'b1, KB);
        step("R10 tick was ignored, still closed", 1'b0, 1'b1, KB);
        idle("R6 period expiry", 9);
        step("R7 saturate with bad key", 1'b0, 1'b1, 16'h0BAD);
        step("R2 token unchanged after bad", 1'b0, 1'b1, 16'h0000);
        @(negedge clk); cfg_timeout_mode = 1'b1;
        step("R5 timeout mode good at start", 1'b0, 1'b1, token);
        step("R5 timeout mode bad key", 1'b0, 1'b1, 16'hFFFF);
        idle("R6 timeout mode expiry", 17);
        step("R1 settle", 1'b0, 1'b0, 16'h0);

        cfg_timeout_mode = 1'b0;
        do_reset();
        idle("R9 initial phase runs out", INIT + 3);
        step("R9 late good key still closes phase", 1'b0, 1'b1, KA);
        step("R9 settle", 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule